// File: doc/BRIEF.md
# One-wire bus bit-rate tick divider

This block turns a fast reference clock into the bit-timing strobe that a one-wire thermal-management bus controller uses. The strobe is a single-cycle enable pulse, `bit_tick`, in the reference clock domain. It is not a derived clock net, so the controller that consumes it stays synchronous to the reference clock.

The pulse period is the product of three cascaded stages:
- a fixed prescaler that divides by four;
- an odd divider that divides by 4·m + 1, where m is an 8-bit timing setting;
- a power-of-two divider that divides by 2^e, where e is a 3-bit exponent.

Together they give a period of 4 × (4·m + 1) × 2^e reference cycles. Choosing m and e for a wanted bus rate is left to software. The block only realises the chosen ratio.

Two timing settings are presented, one for the message phase and one for the address phase. The divider counts only when both settings agree and are non-zero. Otherwise it raises `setup_bad` and produces no ticks, which is a rate of zero. A run input gates counting as a whole.

The period in use is captured when counting starts and again at each terminal count. Changes to the settings in the middle of a period therefore never shorten or stretch that period.

Top module: `peci_bitclk_div`

## Requirements
- R1: While `rst_n` is low, `bit_tick` is 0 and all stage counters are cleared.
- R2: With `run_en` high and a valid setup, the first `bit_tick` comes exactly P = 4 × (4·m + 1) × 2^e reference cycles after the first active edge. Later ticks follow every P cycles.
- R3: `bit_tick` is high for exactly one reference cycle per period.
- R4: While `run_en` is low, `bit_tick` stays 0 and every stage counter is held at zero. When `run_en` rises again, the next tick comes after a full period P.
- R5: When `msg_timing` differs from `addr_timing`, `setup_bad` is 1 in the same cycle, `bit_tick` stays 0 and the counters are cleared.
- R6: A timing value of 0 counts as an invalid setup. `setup_bad` is 1 and no tick is produced.
- R7: New values of m or e applied while counting take effect only after the next tick. The period in progress keeps its length, and the period that follows has the new length.
- R8: The exponent covers 0 through 7, so the largest exponent multiplies the period by 128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Global count enable |
| msg_timing | input | 8 | Timing setting m for the message phase |
| addr_timing | input | 8 | Timing setting for the address phase; must equal `msg_timing` |
| div_exp | input | 3 | Power-of-two exponent e |
| bit_tick | output | 1 | One-cycle strobe at the divided rate |
| setup_bad | output | 1 | High when the timing settings disagree or are zero |

## Verification
A stage counter that wraps at the wrong limit, or advances without its lower stage's carry, shows up as a tick that comes early or late. The bench detects this at the first tick after enabling, at the latest P cycles in. A latch that captures new settings at the wrong moment shows up as a wrong length for the period in progress, one tick after the change. The bench compares every cycle against a behavioural period counter, so any error in the validity decode shows immediately on `setup_bad`, or as a stray tick within one period.

// File: rtl/peci_div_pkg.sv
package peci_div_pkg;
  // log2 of the fixed prescaler (divide by four)
  localparam int unsigned PRE_LOG2 = 2;
  // default field widths
  localparam int unsigned TIMING_W_DEF = 8;
  localparam int unsigned EXP_W_DEF    = 3;
  // odd stage steps through 4*m+1 states, so it needs two extra bits
  localparam int unsigned ODD_EXTRA    = 2;
endpackage

// File: rtl/peci_div_stage.sv
module peci_div_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         at_end
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign at_end = (cnt_q == limit);
  assign cnt_en = clr | step;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (at_end) cnt_d = '0;
    else             cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/peci_div_cfg.sv
module peci_div_cfg #(
  parameter int unsigned TW = 8,
  parameter int unsigned EW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] msg_t,
  input  logic [TW-1:0] addr_t,
  input  logic [EW-1:0] exp_in,
  output logic [TW-1:0] m_q,
  output logic [EW-1:0] e_q,
  output logic          bad
);
  logic [TW-1:0] m_d;
  logic [EW-1:0] e_d;

  assign bad = (msg_t != addr_t) || (msg_t == '0);

  always_comb begin
    m_d = msg_t;
    e_d = exp_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
      e_q <= '0;
    end else if (load) begin
      m_q <= m_d;
      e_q <= e_d;
    end
  end
endmodule

// File: rtl/peci_bitclk_div.sv
module peci_bitclk_div
  import peci_div_pkg::*;
#(
  parameter int unsigned TIMING_W = TIMING_W_DEF,
  parameter int unsigned EXP_W    = EXP_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic [TIMING_W-1:0] msg_timing,
  input  logic [TIMING_W-1:0] addr_timing,
  input  logic [EXP_W-1:0]    div_exp,
  output logic                bit_tick,
  output logic                setup_bad
);
  localparam int unsigned ODD_W = TIMING_W + ODD_EXTRA;
  localparam int unsigned POW_W = (1 << EXP_W) - 1;

  logic                active;
  logic                pre_end, odd_end, pow_end, period_end;
  logic [TIMING_W-1:0] m_q;
  logic [EXP_W-1:0]    e_q;
  logic [ODD_W-1:0]    odd_lim;
  logic [POW_W-1:0]    pow_lim;
  logic                tick_q, tick_d;

  assign active     = run_en & ~setup_bad;
  assign period_end = active & pre_end & odd_end & pow_end;

  peci_div_cfg #(.TW(TIMING_W), .EW(EXP_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (~active | period_end),
    .msg_t  (msg_timing),
    .addr_t (addr_timing),
    .exp_in (div_exp),
    .m_q    (m_q),
    .e_q    (e_q),
    .bad    (setup_bad)
  );

  always_comb begin
    odd_lim = {m_q, {ODD_EXTRA{1'b0}}};
    pow_lim = (POW_W'(1) << e_q) - POW_W'(1);
  end

  peci_div_stage #(.W(PRE_LOG2)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (~active),
    .step   (active),
    .limit  ({PRE_LOG2{1'b1}}),
    .at_end (pre_end)
  );

  peci_div_stage #(.W(ODD_W)) u_odd (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (~active),
    .step   (active & pre_end),
    .limit  (odd_lim),
    .at_end (odd_end)
  );

  peci_div_stage #(.W(POW_W)) u_pow (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (~active),
    .step   (active & pre_end & odd_end),
    .limit  (pow_lim),
    .at_end (pow_end)
  );

  always_comb tick_d = period_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_d;
  end

  assign bit_tick = tick_q;
endmodule

// File: rtl/peci_bitclk_div_chk.sv
module peci_bitclk_div_chk #(
  parameter int unsigned TIMING_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                run_en,
  input logic [TIMING_W-1:0] msg_timing,
  input logic [TIMING_W-1:0] addr_timing,
  input logic                bit_tick,
  input logic                setup_bad
);
  // smallest legal period: 4 * (4*1+1) * 1 = 20 cycles
  localparam int unsigned MIN_GAP = 19;
  logic [15:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                gap_q <= '0;
    else if (bit_tick || !run_en || setup_bad) gap_q <= '0;
    else if (gap_q != 16'hFFFF)                gap_q <= gap_q + 16'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!bit_tick);
    end
  end

  p_period_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (gap_q >= 16'(MIN_GAP)));

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !bit_tick);

  p_mismatch_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_timing != addr_timing) |=> !bit_tick);

  p_zero_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_timing == '0) |=> !bit_tick);

  p_bad_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    setup_bad |=> !bit_tick);
endmodule

bind peci_bitclk_div peci_bitclk_div_chk #(.TIMING_W(TIMING_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_en      (run_en),
  .msg_timing  (msg_timing),
  .addr_timing (addr_timing),
  .bit_tick    (bit_tick),
  .setup_bad   (setup_bad)
);

// File: tb/peci_bitclk_div_bench.sv
`timescale 1ns/1ps
module peci_bitclk_div_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       run_en;
  logic [7:0] msg_timing, addr_timing;
  logic [2:0] div_exp;
  logic       bit_tick, setup_bad;

  int    vectors = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  peci_bitclk_div u_peci_bitclk_div (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .msg_timing(msg_timing), .addr_timing(addr_timing), .div_exp(div_exp),
    .bit_tick(bit_tick), .setup_bad(setup_bad)
  );

  // behavioural reference: one integer period counter
  int m_cnt, m_per;
  bit m_tick;
  function automatic int period_of(int m, int e);
    return 4 * (4 * m + 1) * (1 << e);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_tick = 0; m_per = 0;
    end else if (!(run_en && msg_timing == addr_timing && msg_timing != 0)) begin
      m_cnt = 0; m_tick = 0; m_per = period_of(msg_timing, div_exp);
    end else if (m_cnt == m_per - 1) begin
      m_tick = 1; m_cnt = 0; m_per = period_of(msg_timing, div_exp);
    end else begin
      m_cnt++; m_tick = 0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit exp_bad;
      exp_bad = (msg_timing != addr_timing) || (msg_timing == 0);
      vectors++;
      if (bit_tick !== m_tick) begin
        fails++;
        $display("FAIL %s bit_tick=%0b expected %0b at %0t", cur_req, bit_tick, m_tick, $time);
      end
      vectors++;
      if (setup_bad !== exp_bad) begin
        fails++;
        $display("FAIL %s setup_bad=%0b expected %0b at %0t", cur_req, setup_bad, exp_bad, $time);
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic setup(int m, int a, int e);
    @(negedge clk);
    run_en = 0; msg_timing = 8'(m); addr_timing = 8'(a); div_exp = 3'(e);
    repeat (3) @(negedge clk);
  endtask

  // counts sample points up to the next tick, giving up after lim
  task automatic wait_tick(int lim, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!bit_tick && n < lim);
  endtask

  task automatic measure(int m, int e, string req);
    int p, n;
    p = period_of(m, e);
    cur_req = req;
    setup(m, m, e);
    run_en = 1;
    wait_tick(p + 10, n);
    check(n == p, req, "first tick delay", n, p);
    @(negedge clk);
    check(bit_tick == 0, "R3", "tick width", int'(bit_tick), 0);
    begin
      int k;
      wait_tick(p + 10, k);
      n = k + 1;
    end
    check(n == p, req, "tick spacing", n, p);
  endtask

  initial begin
    int n;
    rst_n = 0; run_en = 0; msg_timing = 8'd1; addr_timing = 8'd1; div_exp = 3'd0;
    repeat (4) @(negedge clk);
    check(bit_tick == 0, "R1", "tick in reset", int'(bit_tick), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(bit_tick == 0, "R1", "tick after reset", int'(bit_tick), 0);

    measure(1, 0, "R2");
    measure(2, 1, "R2");
    measure(3, 2, "R2");
    measure(5, 3, "R2");
    measure(255, 0, "R2");
    measure(1, 7, "R8");

    // R4: stop mid-period, stay quiet, restart with a full period
    cur_req = "R4";
    setup(3, 3, 1);
    run_en = 1;
    repeat (50) @(negedge clk);
    run_en = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i % 10 == 0) check(bit_tick == 0, "R4", "tick while stopped", int'(bit_tick), 0);
    end
    run_en = 1;
    wait_tick(period_of(3, 1) + 10, n);
    check(n == period_of(3, 1), "R4", "restart delay", n, period_of(3, 1));

    // R5: mismatched timings
    cur_req = "R5";
    setup(3, 4, 0);
    run_en = 1;
    @(negedge clk);
    check(setup_bad == 1, "R5", "mismatch flag", int'(setup_bad), 1);
    wait_tick(300, n);
    check(n == 300 && !bit_tick, "R5", "no tick on mismatch", n, 300);

    // R6: zero timing
    cur_req = "R6";
    setup(0, 0, 2);
    run_en = 1;
    @(negedge clk);
    check(setup_bad == 1, "R6", "zero flag", int'(setup_bad), 1);
    wait_tick(300, n);
    check(n == 300 && !bit_tick, "R6", "no tick at zero", n, 300);

    // R7: change mid-period, takes effect after next tick
    cur_req = "R7";
    setup(2, 2, 0);
    run_en = 1;
    repeat (10) @(negedge clk);
    msg_timing = 8'd1; addr_timing = 8'd1; div_exp = 3'd1;
    wait_tick(100, n);
    check(n + 10 == period_of(2, 0), "R7", "old period kept", n + 10, period_of(2, 0));
    wait_tick(100, n);
    check(n == period_of(1, 1), "R7", "new period used", n, period_of(1, 1));

    run_en = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule